// File: doc/BRIEF.md
# LED connectivity test sequencer

This block runs the connection test of a multi-channel LED driver. In pin mode it watches a single test input and drives a single result output. The first high level after reset answers whether the unit is alive. If that answer was 1, each later high phase of an externally toggled pattern reports one LED channel's connection. The high phase after the last channel is a disengage step that ends test mode.

In register mode, a write of a start code to the test register runs the same per-channel check. The check is paced one channel per bus-clock tick. A read of the same register returns the packed result with a completion flag.

The analog sensing is outside the block and arrives as one "connected" bit per channel. The unit's health arrives as a single input. The test input is asynchronous and passes through a synchronizer before the sequencer uses it.

Top module: `led_test_seq`

## Requirements
- R1: Whenever the test input, as seen after its three-register path (two synchronizer stages plus the output register), is low, `test_out` is low.
- R2: On the first high level after reset, `test_out` equals `unit_ok` three clock edges after the raw input rises.
- R3: If that first answer was 0, `test_out` stays 0 on every later high level until reset.
- R4: After an answer of 1, the k-th following high phase (k = 1..NCH) drives `test_out` to `led_ok[k-1]`.
- R5: The high phase after channel NCH drives `test_out` low and ends test mode. Every later high phase also reads 0 until reset.
- R6: The step counter advances only on a rising edge of the synchronized input, so a long high phase keeps one value.
- R7: A write of 0x01 to address 0x0C starts the register test and clears the pass bits and the done flag.
- R8: The register test samples one channel per `bus_tick`, channel 0 first. After NCH ticks it sets done and stops sampling.
- R9: A read of address 0x0C returns bit 7 = done, bits 6:5 = 0 and bits 4:0 = pass bits, registered one cycle after `reg_rd`. A read of any other address returns 0.
- R10: A write to 0x0C with data other than 0x01, or a write to another address, leaves the result unchanged.
- R11: Synchronous active-high reset drives `test_out` and `reg_rdata` to 0 and returns both sequencers to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_in | input | 1 | Asynchronous test stimulus pin |
| unit_ok | input | 1 | Unit health indication for the alive answer |
| led_ok | input | NCH | Per-channel LED connected flags |
| test_out | output | 1 | Registered test result pin |
| bus_tick | input | 1 | One-cycle pulse per bus clock, paces register test |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |

## Verification
Six health and connection patterns are run through both modes. They are all-connected, none connected, two alternating masks, an irregular mask and a dead unit. Together they separate a channel-index slip from a stuck output, and a dead-unit abort from a pattern that is merely all-zero. Directed cases cover a long high phase (no extra step) and highs after disengage. They also cover a reset in the middle of the pattern, a part-way register read, writes that must be ignored, and reads of other addresses.

// File: rtl/led_test_pkg.sv
package led_test_pkg;
  typedef enum logic [1:0] {
    PIN_IDLE = 2'd0,
    PIN_TEST = 2'd1,
    PIN_OFF  = 2'd2
  } pin_state_e;
endpackage

// File: rtl/led_test_sync.sv
module led_test_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level,
  output logic rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], async_in};
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/led_test_pinseq.sv
module led_test_pinseq
  import led_test_pkg::*;
#(
  parameter int NCH = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           level,
  input  logic           rise,
  input  logic           unit_ok,
  input  logic [NCH-1:0] led_ok,
  output logic           test_out
);
  localparam int STEP_W = $clog2(NCH + 2);

  pin_state_e        state, state_n;
  logic [STEP_W-1:0] step, step_n;
  logic              show;

  always_comb begin
    state_n = state;
    step_n  = step;
    unique case (state)
      PIN_IDLE: if (rise) begin
        state_n = unit_ok ? PIN_TEST : PIN_OFF;
        step_n  = '0;
      end
      PIN_TEST: if (rise) begin
        if (step == STEP_W'(NCH)) begin
          state_n = PIN_OFF;
          step_n  = '0;
        end else begin
          step_n = step + STEP_W'(1);
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    show = 1'b0;
    if (state_n == PIN_TEST) begin
      if (step_n == '0) show = 1'b1;
      for (int i = 0; i < NCH; i++)
        if (step_n == STEP_W'(i + 1)) show = led_ok[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= PIN_IDLE;
      step     <= '0;
      test_out <= 1'b0;
    end else begin
      state    <= state_n;
      step     <= step_n;
      test_out <= level & show;
    end
  end

  // R2: alive answer follows unit health
  a_r2_ack_value: assert property (@(posedge clk) disable iff (rst)
    (state == PIN_IDLE && rise) |=> (test_out == $past(unit_ok)));
  // R3/R5: once disengaged or refused, stays off
  a_r5_off_sticky: assert property (@(posedge clk) disable iff (rst)
    (state == PIN_OFF) |=> (state == PIN_OFF));
  a_r3_off_silent: assert property (@(posedge clk) disable iff (rst)
    (state == PIN_OFF) |=> !test_out);
  // R6: step moves only on a rising edge
  a_r6_step_on_rise: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(step));
  // R4: step index never passes the last channel
  a_r4_step_bound: assert property (@(posedge clk) disable iff (rst)
    step <= STEP_W'(NCH));
endmodule

// File: rtl/led_test_regseq.sv
module led_test_regseq #(
  parameter int              NCH        = 5,
  parameter int              ADDR_W     = 8,
  parameter int              DATA_W     = 8,
  parameter logic [ADDR_W-1:0] TEST_ADDR  = 8'h0C,
  parameter logic [DATA_W-1:0] START_CODE = 8'h01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_tick,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [NCH-1:0]    led_ok,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int IDX_W = $clog2(NCH + 1);

  logic              running, done, start, step_en;
  logic [IDX_W-1:0]  idx;
  logic [NCH-1:0]    pass;
  logic [DATA_W-1:0] word;

  assign start   = reg_wr && (reg_addr == TEST_ADDR) && (reg_wdata == START_CODE);
  assign step_en = running && bus_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      done    <= 1'b0;
      idx     <= '0;
    end else if (start) begin
      running <= 1'b1;
      done    <= 1'b0;
      idx     <= '0;
    end else if (step_en) begin
      if (idx == IDX_W'(NCH - 1)) begin
        running <= 1'b0;
        done    <= 1'b1;
      end else begin
        idx <= idx + IDX_W'(1);
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_pass
    always_ff @(posedge clk) begin
      if (rst || start)                      pass[g] <= 1'b0;
      else if (step_en && idx == IDX_W'(g))  pass[g] <= led_ok[g];
    end
  end

  always_comb begin
    word            = '0;
    word[DATA_W-1]  = done;
    word[NCH-1:0]   = pass;
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= (reg_addr == TEST_ADDR) ? word : '0;
  end

  // R7: start clears the result
  a_r7_start_clears: assert property (@(posedge clk) disable iff (rst)
    start |=> (!done && pass == '0));
  // R9: other addresses read zero
  a_r9_other_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr != TEST_ADDR) |=> (reg_rdata == '0));
  // R10/R8: result only moves on a start or a paced step
  a_r10_pass_hold: assert property (@(posedge clk) disable iff (rst)
    (!start && !step_en) |=> $stable(pass));
  // R8: done and running never together
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    !(done && running));
endmodule

// File: rtl/led_test_seq.sv
module led_test_seq #(
  parameter int              NCH         = 5,
  parameter int              SYNC_STAGES = 2,
  parameter int              ADDR_W      = 8,
  parameter int              DATA_W      = 8,
  parameter logic [ADDR_W-1:0] TEST_ADDR   = 8'h0C,
  parameter logic [DATA_W-1:0] START_CODE  = 8'h01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              test_in,
  input  logic              unit_ok,
  input  logic [NCH-1:0]    led_ok,
  output logic              test_out,
  input  logic              bus_tick,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  logic t_level, t_rise;

  led_test_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(test_in), .level(t_level), .rise(t_rise)
  );

  led_test_pinseq #(.NCH(NCH)) u_pin (
    .clk(clk), .rst(rst), .level(t_level), .rise(t_rise),
    .unit_ok(unit_ok), .led_ok(led_ok), .test_out(test_out)
  );

  led_test_regseq #(
    .NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .TEST_ADDR(TEST_ADDR), .START_CODE(START_CODE)
  ) u_reg (
    .clk(clk), .rst(rst), .bus_tick(bus_tick), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .led_ok(led_ok), .reg_rdata(reg_rdata)
  );

  // R1: a low input (after sync and output register) forces a low result
  a_r1_low_forces_low: assert property (@(posedge clk) disable iff (rst)
    !$past(test_in, SYNC_STAGES + 1) |-> !test_out);
endmodule

// File: tb/led_test_seq_test.sv
module led_test_seq_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       test_in = 1'b0;
  logic       unit_ok = 1'b0;
  logic [4:0] led_ok = '0;
  logic       test_out;
  logic       bus_tick = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;

  int n_checks = 0;
  int n_errs   = 0;

  always #4 clk = ~clk;

  led_test_seq uut (
    .clk(clk), .rst(rst), .test_in(test_in), .unit_ok(unit_ok), .led_ok(led_ok),
    .test_out(test_out), .bus_tick(bus_tick), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // {unit_ok, led_ok[4:0]}
  localparam logic [5:0] VEC [6] = '{
    6'b1_11111, 6'b1_00000, 6'b1_10101, 6'b1_01010, 6'b0_11111, 6'b1_10011
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; test_in = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic phase(input logic lvl);
    @(negedge clk); test_in = lvl;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); bus_tick = 1'b1;
    @(negedge clk); bus_tick = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  initial begin
    #(8 * 150000);
    n_errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    check("R11 reset test_out", {7'd0, test_out}, 8'h00);
    check("R11 reset rdata", reg_rdata, 8'h00);
    rst = 1'b0;

    for (int v = 0; v < 6; v++) begin
      do_reset();
      unit_ok = VEC[v][5];
      led_ok  = VEC[v][4:0];
      phase(1'b1);
      check("R2 alive answer", {7'd0, test_out}, {7'd0, unit_ok});
      for (int k = 1; k <= 6; k++) begin
        phase(1'b0);
        check("R1 low phase", {7'd0, test_out}, 8'h00);
        phase(1'b1);
        if (!unit_ok)
          check("R3 refused unit silent", {7'd0, test_out}, 8'h00);
        else if (k <= 5)
          check("R4 channel step", {7'd0, test_out}, {7'd0, led_ok[k-1]});
        else
          check("R5 disengage step", {7'd0, test_out}, 8'h00);
      end
      phase(1'b0);
      phase(1'b1);
      check("R5 after disengage", {7'd0, test_out}, 8'h00);

      wr(8'h0C, 8'h01);
      rd(8'h0C, d);
      check("R7 start clears", d, 8'h00);
      tick(); tick();
      rd(8'h0C, d);
      check("R8 partial run", d, {3'b000, led_ok & 5'b00011});
      tick(); tick(); tick();
      rd(8'h0C, d);
      check("R9 packed result", d, {3'b100, led_ok});
      tick();
      rd(8'h0C, d);
      check("R8 stops after done", d, {3'b100, led_ok});
    end

    // R6: long high holds one step
    do_reset();
    unit_ok = 1'b1; led_ok = 5'b00010;
    phase(1'b1);
    phase(1'b0);
    phase(1'b1);
    check("R6 first channel", {7'd0, test_out}, 8'h00);
    repeat (20) @(negedge clk);
    check("R6 long high same step", {7'd0, test_out}, 8'h00);
    phase(1'b0);
    phase(1'b1);
    check("R6 next channel", {7'd0, test_out}, 8'h01);

    // R11: reset mid-pattern restarts with alive answer
    do_reset();
    check("R11 test_out after reset", {7'd0, test_out}, 8'h00);
    phase(1'b1);
    check("R11 alive again", {7'd0, test_out}, 8'h01);

    // R10: ignored writes, R9 other address
    led_ok = 5'b01101;
    wr(8'h0C, 8'h01);
    repeat (5) tick();
    led_ok = 5'b10010;
    wr(8'h0C, 8'h02);
    rd(8'h0C, d);
    check("R10 wrong code ignored", d, 8'h8D);
    wr(8'h0D, 8'h01);
    rd(8'h0C, d);
    check("R10 wrong address ignored", d, 8'h8D);
    rd(8'h0D, d);
    check("R9 other address zero", d, 8'h00);
    do_reset();
    rd(8'h0C, d);
    check("R11 result cleared", d, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule